// File: doc/BRIEF.md
# Keyed-Commit Memory Remap Controller

This block sits on an 8-bit peripheral bus and decides how a boot ROM, a RAM region and the vector table are overlaid onto the code and data address spaces of a small microcontroller. Software writes the mapping it wants into a staging register. That value stays pending, and has no effect on address steering, until a fixed key byte is written to a separate commit register. Only then is the staged value copied into the active mapping.

A read-only status register reports the active mapping. The control register reads back the staged value, so software can check a pending change against the live one before it commits. The block also decodes every code-space and data-space address into a memory select (main ROM, boot ROM or RAM) and an index into the chosen memory. This steering always follows the active mapping.

Top module: `keyed_remap`

## Requirements
- R1: After reset, the staged and active mappings are both zero. Reads of the control register (0x0FD0) and of the status register (0x0FDF) return 0x00, and the boot ROM is not mapped.
- R2: A bus write to 0x0FD0 stores data bits [2:0] as the staged mapping: bit0 maps RAM into the code space, bit1 relocates the vectors, bit2 enables the boot ROM. The write leaves the active mapping unchanged. A read of 0x0FD0 returns {5'b0, staged}.
- R3: A bus write of 0xD5 to 0x0FD1 copies the staged mapping into the active mapping on that clock edge. Address decodes made during the write cycle still use the old mapping, and decodes from the next cycle on use the new one.
- R4: A write to 0x0FD1 with any value other than 0xD5 leaves the active mapping unchanged.
- R5: A read of 0x0FDF returns {5'b0, active}, using the same bit positions as R2. Bits 7 to 3 always read 0. Writes to 0x0FDF are ignored.
- R6: While the active boot enable is 1, code and data addresses from 0x1000 to 0x17FF give select 1 (boot ROM), with index = address bits [10:0].
- R7: A code address claimed by no active overlay gives select 0 (main ROM) with index = address. This includes 0x1000 to 0x17FF when the boot ROM is off.
- R8: While RAM-in-code is active, code addresses from 0x0800 to 0x0FFF give select 2 (RAM), with index = address - 0x0800.
- R9: While vector relocation is active, code addresses from 0xFFC0 to 0xFFFF give select 2 (RAM), with index = 0x0700 + (address - 0xFFC0).
- R10: Outside the boot ROM window, data addresses from 0x0040 to 0x083F give select 2 with index = address - 0x0040. All other data addresses give select 0 with index = address.
- R11: A read with the read enable low, or a read of any address other than 0x0FD0 or 0x0FDF (including 0x0FD1), returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 12 | Peripheral bus address |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data (combinational) |
| codeAddr | input | 16 | Code-space address to decode |
| codeSel | output | 2 | Code memory select: 0 ROM, 1 boot ROM, 2 RAM |
| codeIdx | output | 16 | Index into the selected code memory |
| dataAddr | input | 16 | Data-space address to decode |
| dataSel | output | 2 | Data memory select: 0 ROM, 1 boot ROM, 2 RAM |
| dataIdx | output | 16 | Index into the selected data memory |

## Verification
A key write to the commit register and an address decode can fall in the same cycle, so the bench drives code and data addresses inside the affected windows during the commit cycle itself. The decode in that cycle must follow the old mapping, and the decode in the following cycle must follow the new one. A behavioural model updates its active mapping only at the clock edge that ends the key write, and it compares both selects and indices on every cycle. This catches a commit that lands one cycle early or one cycle late.

// File: rtl/keyed_remap_pkg.sv
package keyed_remap_pkg;

  // mapping bits; packing order gives bit2 boot, bit1 vectors, bit0 RAM in code
  typedef struct packed {
    logic bootEn;
    logic vecReloc;
    logic ramInCode;
  } map_t;

  localparam int unsigned MAP_W = $bits(map_t);

  typedef enum logic [1:0] {
    SEL_ROM  = 2'd0,
    SEL_BOOT = 2'd1,
    SEL_RAM  = 2'd2
  } sel_t;

  // strobes from the bus decoder to the register datapath
  typedef struct packed {
    logic stageWr;
    logic commit;
    logic rdCtrl;
    logic rdStat;
  } strobe_t;

endpackage

// File: rtl/keyed_remap_ctrl.sv
module keyed_remap_ctrl
  import keyed_remap_pkg::*;
#(
  parameter int unsigned BUS_AW      = 12,
  parameter int unsigned BUS_DW      = 8,
  parameter int unsigned CTRL_ADDR   = 12'hFD0,
  parameter int unsigned COMMIT_ADDR = 12'hFD1,
  parameter int unsigned STAT_ADDR   = 12'hFDF,
  parameter int unsigned COMMIT_KEY  = 8'hD5
) (
  input  logic [BUS_AW-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [BUS_DW-1:0] busWrData,
  output strobe_t           stb
);

  localparam logic [BUS_AW-1:0] CTRL_A   = BUS_AW'(CTRL_ADDR);
  localparam logic [BUS_AW-1:0] COMMIT_A = BUS_AW'(COMMIT_ADDR);
  localparam logic [BUS_AW-1:0] STAT_A   = BUS_AW'(STAT_ADDR);
  localparam logic [BUS_DW-1:0] KEY      = BUS_DW'(COMMIT_KEY);

  logic hitCtrl, hitCommit, hitStat, keyMatch;

  always_comb begin
    hitCtrl   = (busAddr == CTRL_A);
    hitCommit = (busAddr == COMMIT_A);
    hitStat   = (busAddr == STAT_A);
    keyMatch  = (busWrData == KEY);
  end

  // the status register has no write strobe, so writes to it do nothing
  always_comb begin
    stb.stageWr = busWrEn & hitCtrl;
    stb.commit  = busWrEn & hitCommit & keyMatch;
    stb.rdCtrl  = busRdEn & hitCtrl;
    stb.rdStat  = busRdEn & hitStat;
  end

endmodule

// File: rtl/keyed_remap_datapath.sv
module keyed_remap_datapath
  import keyed_remap_pkg::*;
#(
  parameter int unsigned BUS_DW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [MAP_W-1:0]  stageData,
  output map_t              stagedMap,
  output map_t              activeMap,
  output logic [BUS_DW-1:0] rdData
);

  localparam int unsigned PAD_W = BUS_DW - MAP_W;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stagedMap <= '0;
    end else if (stb.stageWr) begin
      stagedMap <= map_t'(stageData);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeMap <= '0;
    end else if (stb.commit) begin
      activeMap <= stagedMap;
    end
  end

  always_comb begin
    rdData = '0;
    if (stb.rdCtrl) begin
      rdData = {{PAD_W{1'b0}}, stagedMap};
    end else if (stb.rdStat) begin
      rdData = {{PAD_W{1'b0}}, activeMap};
    end
  end

endmodule

// File: rtl/keyed_remap_steer.sv
module keyed_remap_steer
  import keyed_remap_pkg::*;
#(
  parameter int unsigned ADDR_W       = 16,
  parameter int unsigned BOOT_BASE    = 16'h1000,
  parameter int unsigned BOOT_SIZE    = 2048,
  parameter int unsigned VEC_BASE     = 16'hFFC0,
  parameter int unsigned VEC_SIZE     = 64,
  parameter int unsigned VEC_RAM_BASE = 16'h0700,
  parameter int unsigned RAM_BASE     = 16'h0800,
  parameter int unsigned RAM_SIZE     = 2048
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              bootOn,
  input  logic              vecOn,
  input  logic              ramOn,
  output sel_t              sel,
  output logic [ADDR_W-1:0] idx
);

  localparam int unsigned BOOT_IDX_W = $clog2(BOOT_SIZE);
  localparam logic [ADDR_W-1:0] BOOT_LO = ADDR_W'(BOOT_BASE);
  localparam logic [ADDR_W-1:0] BOOT_HI = ADDR_W'(BOOT_BASE + BOOT_SIZE - 1);
  localparam logic [ADDR_W-1:0] VEC_LO  = ADDR_W'(VEC_BASE);
  localparam logic [ADDR_W-1:0] VEC_HI  = ADDR_W'(VEC_BASE + VEC_SIZE - 1);
  localparam logic [ADDR_W-1:0] RAM_LO  = ADDR_W'(RAM_BASE);
  localparam logic [ADDR_W-1:0] RAM_HI  = ADDR_W'(RAM_BASE + RAM_SIZE - 1);
  localparam logic [ADDR_W-1:0] VEC_RAM = ADDR_W'(VEC_RAM_BASE);

  logic inBoot, inVec, inRam;

  always_comb begin
    inBoot = (addr >= BOOT_LO) && (addr <= BOOT_HI);
    inVec  = (addr >= VEC_LO)  && (addr <= VEC_HI);
    inRam  = (addr >= RAM_LO)  && (addr <= RAM_HI);
  end

  // priority: boot window, then relocated vectors, then RAM window, then ROM
  always_comb begin
    sel = SEL_ROM;
    idx = addr;
    if (bootOn && inBoot) begin
      sel = SEL_BOOT;
      idx = ADDR_W'(addr[BOOT_IDX_W-1:0]);
    end else if (vecOn && inVec) begin
      sel = SEL_RAM;
      idx = VEC_RAM + (addr - VEC_LO);
    end else if (ramOn && inRam) begin
      sel = SEL_RAM;
      idx = addr - RAM_LO;
    end
  end

endmodule

// File: rtl/keyed_remap.sv
module keyed_remap
  import keyed_remap_pkg::*;
#(
  parameter int unsigned BUS_AW         = 12,
  parameter int unsigned BUS_DW         = 8,
  parameter int unsigned ADDR_W         = 16,
  parameter int unsigned CTRL_ADDR      = 12'hFD0,
  parameter int unsigned COMMIT_ADDR    = 12'hFD1,
  parameter int unsigned STAT_ADDR      = 12'hFDF,
  parameter int unsigned COMMIT_KEY     = 8'hD5,
  parameter int unsigned BOOT_BASE      = 16'h1000,
  parameter int unsigned BOOT_SIZE      = 2048,
  parameter int unsigned VEC_BASE       = 16'hFFC0,
  parameter int unsigned VEC_SIZE       = 64,
  parameter int unsigned VEC_RAM_BASE   = 16'h0700,
  parameter int unsigned CODE_RAM_BASE  = 16'h0800,
  parameter int unsigned CODE_RAM_SIZE  = 2048,
  parameter int unsigned DATA_RAM_BASE  = 16'h0040,
  parameter int unsigned DATA_RAM_SIZE  = 2048
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [BUS_AW-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [BUS_DW-1:0] busWrData,
  output logic [BUS_DW-1:0] busRdData,
  input  logic [ADDR_W-1:0] codeAddr,
  output logic [1:0]        codeSel,
  output logic [ADDR_W-1:0] codeIdx,
  input  logic [ADDR_W-1:0] dataAddr,
  output logic [1:0]        dataSel,
  output logic [ADDR_W-1:0] dataIdx
);

  strobe_t stb;
  map_t    stagedMap;
  map_t    activeMap;
  sel_t    codeSelE, dataSelE;

  keyed_remap_ctrl #(
    .BUS_AW(BUS_AW), .BUS_DW(BUS_DW), .CTRL_ADDR(CTRL_ADDR),
    .COMMIT_ADDR(COMMIT_ADDR), .STAT_ADDR(STAT_ADDR), .COMMIT_KEY(COMMIT_KEY)
  ) u_ctrl (
    .busAddr(busAddr), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busWrData(busWrData), .stb(stb)
  );

  keyed_remap_datapath #(.BUS_DW(BUS_DW)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .stageData(busWrData[MAP_W-1:0]),
    .stagedMap(stagedMap), .activeMap(activeMap), .rdData(busRdData)
  );

  keyed_remap_steer #(
    .ADDR_W(ADDR_W), .BOOT_BASE(BOOT_BASE), .BOOT_SIZE(BOOT_SIZE),
    .VEC_BASE(VEC_BASE), .VEC_SIZE(VEC_SIZE), .VEC_RAM_BASE(VEC_RAM_BASE),
    .RAM_BASE(CODE_RAM_BASE), .RAM_SIZE(CODE_RAM_SIZE)
  ) u_code (
    .addr(codeAddr), .bootOn(activeMap.bootEn), .vecOn(activeMap.vecReloc),
    .ramOn(activeMap.ramInCode), .sel(codeSelE), .idx(codeIdx)
  );

  // the data space has no vector overlay and its RAM window is always present
  keyed_remap_steer #(
    .ADDR_W(ADDR_W), .BOOT_BASE(BOOT_BASE), .BOOT_SIZE(BOOT_SIZE),
    .VEC_BASE(VEC_BASE), .VEC_SIZE(VEC_SIZE), .VEC_RAM_BASE(VEC_RAM_BASE),
    .RAM_BASE(DATA_RAM_BASE), .RAM_SIZE(DATA_RAM_SIZE)
  ) u_data (
    .addr(dataAddr), .bootOn(activeMap.bootEn), .vecOn(1'b0),
    .ramOn(1'b1), .sel(dataSelE), .idx(dataIdx)
  );

  assign codeSel = codeSelE;
  assign dataSel = dataSelE;

endmodule

// File: rtl/keyed_remap_chk.sv
module keyed_remap_chk
  import keyed_remap_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic [11:0] busAddr,
  input logic        busWrEn,
  input logic        busRdEn,
  input logic [7:0]  busWrData,
  input logic [7:0]  busRdData,
  input logic [15:0] codeAddr,
  input logic [1:0]  codeSel,
  input logic [15:0] dataAddr,
  input logic [1:0]  dataSel,
  input map_t        stagedMap,
  input map_t        activeMap
);

  assert_stage_only_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 12'hFD0) |=> $stable(activeMap));

  assert_key_commit_R3: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 12'hFD1 && busWrData == 8'hD5) |=> (activeMap == $past(stagedMap)));

  assert_bad_key_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 12'hFD1 && busWrData != 8'hD5) |=> $stable(activeMap));

  assert_status_read_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr == 12'hFDF) |-> (busRdData == {5'b0, activeMap}));

  assert_boot_code_R6: assert property (@(posedge clk) disable iff (!rstN)
    (activeMap.bootEn && codeAddr >= 16'h1000 && codeAddr <= 16'h17FF) |-> (codeSel == 2'd1));

  assert_boot_data_R6: assert property (@(posedge clk) disable iff (!rstN)
    (activeMap.bootEn && dataAddr >= 16'h1000 && dataAddr <= 16'h17FF) |-> (dataSel == 2'd1));

  assert_boot_off_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!activeMap.bootEn && codeAddr >= 16'h1000 && codeAddr <= 16'h17FF) |-> (codeSel == 2'd0));

  assert_idle_read_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!busRdEn) |-> (busRdData == 8'h00));

endmodule

bind keyed_remap keyed_remap_chk u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
  .busRdEn(busRdEn), .busWrData(busWrData), .busRdData(busRdData),
  .codeAddr(codeAddr), .codeSel(codeSel), .dataAddr(dataAddr),
  .dataSel(dataSel), .stagedMap(stagedMap), .activeMap(activeMap)
);

// File: tb/keyed_remap_bench.sv
`timescale 1ns/1ps
module keyed_remap_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] busAddr = '0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [7:0]  busWrData = '0;
  logic [7:0]  busRdData;
  logic [15:0] codeAddr = '0;
  logic [1:0]  codeSel;
  logic [15:0] codeIdx;
  logic [15:0] dataAddr = '0;
  logic [1:0]  dataSel;
  logic [15:0] dataIdx;

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit running = 0;

  // model state: bit2 boot, bit1 vectors, bit0 RAM in code
  int mStaged = 0;
  int mActive = 0;

  always #2.5 clk = ~clk;

  keyed_remap u_keyed_remap (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busRdEn(busRdEn), .busWrData(busWrData), .busRdData(busRdData),
    .codeAddr(codeAddr), .codeSel(codeSel), .codeIdx(codeIdx),
    .dataAddr(dataAddr), .dataSel(dataSel), .dataIdx(dataIdx)
  );

  task automatic chk(input string tag, input string what, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, got, exp);
    end
  endtask

  function automatic void codeModel(input int a, input int m, output int sel, output int idx, output string tag);
    if ((m & 4) != 0 && a >= 'h1000 && a <= 'h17FF) begin
      sel = 1; idx = a & 'h7FF; tag = "R6";
    end else if ((m & 2) != 0 && a >= 'hFFC0) begin
      sel = 2; idx = 'h0700 + (a - 'hFFC0); tag = "R9";
    end else if ((m & 1) != 0 && a >= 'h0800 && a <= 'h0FFF) begin
      sel = 2; idx = a - 'h0800; tag = "R8";
    end else begin
      sel = 0; idx = a; tag = "R7";
    end
  endfunction

  function automatic void dataModel(input int a, input int m, output int sel, output int idx, output string tag);
    if ((m & 4) != 0 && a >= 'h1000 && a <= 'h17FF) begin
      sel = 1; idx = a & 'h7FF; tag = "R6";
    end else if (a >= 'h0040 && a <= 'h083F) begin
      sel = 2; idx = a - 'h0040; tag = "R10";
    end else begin
      sel = 0; idx = a; tag = "R10";
    end
  endfunction

  // model update at the clock edge
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mStaged <= 0;
      mActive <= 0;
    end else begin
      if (busWrEn && busAddr == 12'hFD0) mStaged <= busWrData & 7;
      if (busWrEn && busAddr == 12'hFD1 && busWrData == 8'hD5) mActive <= mStaged;
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (running && rstN) begin
      int s, i, er;
      string t;
      codeModel(int'(codeAddr), mActive, s, i, t);
      chk(t, "codeSel", int'(codeSel), s);
      chk(t, "codeIdx", int'(codeIdx), i);
      dataModel(int'(dataAddr), mActive, s, i, t);
      chk(t, "dataSel", int'(dataSel), s);
      chk(t, "dataIdx", int'(dataIdx), i);
      er = 0; t = "R11";
      if (busRdEn && busAddr == 12'hFD0) begin er = mStaged; t = "R2"; end
      else if (busRdEn && busAddr == 12'hFDF) begin er = mActive; t = "R5"; end
      chk(t, "busRdData", int'(busRdData), er);
    end
  end

  // start a new cycle with an idle bus
  task automatic nextCycle();
    @(posedge clk);
    #1;
    busWrEn = 1'b0;
    busRdEn = 1'b0;
    busWrData = '0;
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [7:0] d);
    nextCycle();
    busAddr = a; busWrData = d; busWrEn = 1'b1;
  endtask

  task automatic readCheck(input logic [11:0] a, input int exp, input string tag);
    nextCycle();
    busAddr = a; busRdEn = 1'b1;
    @(negedge clk);
    chk(tag, "directed read", int'(busRdData), exp);
  endtask

  task automatic codeCheck(input logic [15:0] a, input int es, input int ei, input string tag);
    nextCycle();
    codeAddr = a;
    @(negedge clk);
    chk(tag, "directed codeSel", int'(codeSel), es);
    chk(tag, "directed codeIdx", int'(codeIdx), ei);
  endtask

  task automatic dataCheck(input logic [15:0] a, input int es, input int ei, input string tag);
    nextCycle();
    dataAddr = a;
    @(negedge clk);
    chk(tag, "directed dataSel", int'(dataSel), es);
    chk(tag, "directed dataIdx", int'(dataIdx), ei);
  endtask

  function automatic logic [15:0] pickAddr(input int r, input bit isCode);
    case (r % 4)
      0: return 16'h1000 + 16'($urandom_range(0, 'h7FF));
      1: return isCode ? 16'hFFC0 + 16'($urandom_range(0, 63)) : 16'h0040 + 16'($urandom_range(0, 'h7FF));
      2: return isCode ? 16'h0800 + 16'($urandom_range(0, 'h7FF)) : 16'h0800 + 16'($urandom_range(0, 'h7F));
      default: return 16'($urandom);
    endcase
  endfunction

  initial begin
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    running = 1;

    // R1 reset state
    readCheck(12'hFD0, 0, "R1");
    readCheck(12'hFDF, 0, "R1");
    codeCheck(16'h1234, 0, 'h1234, "R1");

    // R2 staging only
    busWrite(12'hFD0, 8'hFF);
    readCheck(12'hFD0, 7, "R2");
    readCheck(12'hFDF, 0, "R2");
    codeCheck(16'h1400, 0, 'h1400, "R2");

    // R4 wrong key
    busWrite(12'hFD1, 8'h55);
    readCheck(12'hFDF, 0, "R4");
    busWrite(12'hFD1, 8'hD4);
    readCheck(12'hFDF, 0, "R4");

    // R3 key commit, decode in the same cycle still sees the old map
    busWrite(12'hFD1, 8'hD5);
    codeAddr = 16'h1234;
    @(negedge clk);
    chk("R3", "same-cycle codeSel", int'(codeSel), 0);
    nextCycle();
    @(negedge clk);
    chk("R3", "next-cycle codeSel", int'(codeSel), 1);
    readCheck(12'hFDF, 7, "R3");

    codeCheck(16'h1234, 1, 'h234, "R6");
    dataCheck(16'h17FF, 1, 'h7FF, "R6");
    codeCheck(16'hFFC5, 2, 'h705, "R9");
    codeCheck(16'h0900, 2, 'h100, "R8");
    dataCheck(16'h0050, 2, 'h010, "R10");
    dataCheck(16'h0900, 0, 'h900, "R10");

    // R5 status is read-only
    busWrite(12'hFDF, 8'h00);
    readCheck(12'hFDF, 7, "R5");

    // R11 other reads
    readCheck(12'hFD1, 0, "R11");
    readCheck(12'h123, 0, "R11");

    // boot off again
    busWrite(12'hFD0, 8'h02);
    busWrite(12'hFD1, 8'hD5);
    codeCheck(16'h1234, 0, 'h1234, "R7");
    codeCheck(16'h0900, 0, 'h0900, "R7");
    codeCheck(16'hFFFF, 2, 'h73F, "R9");

    // random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      int op;
      nextCycle();
      op = $urandom_range(0, 99);
      codeAddr = pickAddr($urandom, 1'b1);
      dataAddr = pickAddr($urandom, 1'b0);
      if (op < 25) begin
        busAddr = 12'hFD0; busWrData = 8'($urandom); busWrEn = 1'b1;
      end else if (op < 40) begin
        busAddr = 12'hFD1; busWrData = ($urandom_range(0, 1) != 0) ? 8'hD5 : 8'($urandom); busWrEn = 1'b1;
      end else if (op < 45) begin
        busAddr = 12'hFDF; busWrData = 8'($urandom); busWrEn = 1'b1;
      end else if (op < 65) begin
        busAddr = 12'hFDF; busRdEn = 1'b1;
      end else if (op < 85) begin
        busAddr = 12'hFD0; busRdEn = 1'b1;
      end else begin
        busAddr = 12'($urandom); busRdEn = ($urandom_range(0, 1) != 0);
      end
    end

    nextCycle();
    @(negedge clk);
    running = 0;
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule